// File: doc/BRIEF.md
# Two-Wire Word-Buffered Memory Slave

This block is the slave side of a two-wire serial bus (clock and open-drain data) placed in front of a small nonvolatile array of 32 rows of 16 bits. The bus carries no device address. Each transfer opens with a START and a control byte. The control byte names a row, a transfer mode and the direction. The slave copies the addressed row into a 16-bit word buffer. Write data bytes replace halves of that buffer. Read data bytes are shifted out of it. The mode sets which half travels first and which way the row moves during a sequential read.

A STOP that follows at least one written data byte starts an erase-write cycle, which the array models as a fixed busy time. While that cycle runs, the slave acknowledges nothing, so the master can poll for the end of the cycle with repeated control bytes. A handful of control-byte values are not memory accesses. They are commands for neighbouring logic (modulator selection, supply management). The slave acknowledges them, hands the byte out on a command port, and then ignores the bus until the next STOP.

SCL and SDA are sampled by the system clock through synchronizers, so the bus must run well below the system clock. The command port follows valid/ready rules. The slave raises `cmd_valid_o` together with the code. It holds both unchanged until a cycle in which `cmd_ready_i` is high, and drops valid in the next cycle. While a command is still waiting, any further command byte gets no acknowledge, so no command is lost or overwritten. The master must resend it later.

Top module: `serial_word_mem`

## Requirements
- R1: Control byte bits 7..3 give the row, bits 2..1 give the mode, and bit 0 selects read (1) or write (0). A memory control byte with mode 01 or 10 is acknowledged: the slave pulls SDA low during the ninth clock.
- R2: In a write, mode 01 sends bits 7..0 of the row first and bits 15..8 second. Mode 10 sends bits 15..8 first and bits 7..0 second.
- R3: The buffer is loaded from the addressed row when the control byte is accepted, so a one-byte write leaves the other half of the row unchanged.
- R4: A STOP after one or two acknowledged write data bytes programs the buffer into the row and keeps the array busy for BUSY_CYCLES clocks. While busy, no byte is acknowledged.
- R5: A write made of the control byte alone, followed by STOP, programs nothing. A control byte sent right after it is acknowledged.
- R6: In a read, mode 01 sends the low byte first and moves to row+1 after each word. Mode 10 sends the high byte first and moves to row-1. The row wraps between 31 and 0.
- R7: When the master does not acknowledge a byte the slave sent, the slave releases SDA. It drives nothing more until the next START or STOP.
- R8: A third write data byte is not acknowledged and is not stored. The STOP that follows still programs the first two bytes.
- R9: A control byte matching 11xxx111 (binary) is a command. It is acknowledged and its code is output. The bus, including any START, is then ignored until the next STOP.
- R10: The command code is held stable with `cmd_valid_o` high until `cmd_ready_i` is high. A command byte that arrives while one is still pending is not acknowledged.
- R11: Any other control byte (mode 00, or mode 11 without 11 in bits 7..6, including codes ending in 110) is not acknowledged. The slave stays silent until the next START or STOP.
- R12: After reset, SDA is released, `cmd_valid_o` is low and every row reads as zero.
- R13: The slave only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved serial data line |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| cmd_valid_o | output | 1 | A command byte is waiting on `cmd_code_o` |
| cmd_code_o | output | 8 | The command control byte |
| cmd_ready_i | input | 1 | Consumer accepts the pending command |

## Verification
Directed patterns cover the corner cases. Writes in both byte orders separate the low and high halves. A one-byte write shows whether the buffer was preloaded from the row. Four-byte reads that start at rows 31 and 0 expose wrong step direction and missing wraparound. Polling right after a STOP, and a poll after a control-only write, separate a real busy window from a spurious one. The command sequence holds ready low, sends a START and a second command while one is pending, and so checks the hold and the silence rules. Seeded random writes and reads, with random rows, modes and byte counts, are compared against a row model kept in the bench.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int ROW_W  = 5;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK, ST_SPECIAL, ST_HALT
  } swm_state_e;

  typedef enum logic [1:0] {
    NX_RECV, NX_SEND, NX_SPECIAL, NX_HALT
  } swm_next_e;

  function automatic logic is_command(input logic [BYTE_W-1:0] c);
    return (c[7:6] == 2'b11) && (c[2:0] == 3'b111);
  endfunction

  // second=0 picks the byte that travels first in the given order
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                   input logic lo_first,
                                                   input logic second);
    return (lo_first ^ second) ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], d_i};
  end

  assign level_o = sh[STAGES-1];
  assign rise_o  = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/swm_array.sv
module swm_array #(
  parameter int ROW_BITS    = 5,
  parameter int WIDTH       = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] rd_row_i,
  output logic [WIDTH-1:0]    rd_word_o,
  input  logic                prog_i,
  input  logic [ROW_BITS-1:0] prog_row_i,
  input  logic [WIDTH-1:0]    prog_word_i,
  output logic                busy_o
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [WIDTH-1:0]    cells [ROWS];
  logic [CNT_W-1:0]    cnt;
  logic [ROW_BITS-1:0] pend_row;
  logic [WIDTH-1:0]    pend_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) cells[i] <= '0;
      cnt       <= '0;
      pend_row  <= '0;
      pend_word <= '0;
    end else if (prog_i && cnt == '0) begin
      cnt       <= CNT_W'(BUSY_CYCLES);
      pend_row  <= prog_row_i;
      pend_word <= prog_word_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) cells[pend_row] <= pend_word;
    end
  end

  assign rd_word_o = cells[rd_row_i];
  assign busy_o    = (cnt != '0);

  AST_PROG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |-> !busy_o); // R4
endmodule

// File: rtl/swm_engine.sv
module swm_engine
  import swm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_pull_o,
  output logic [ROW_W-1:0]  rd_row_o,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic              busy_i,
  output logic              prog_o,
  output logic [ROW_W-1:0]  prog_row_o,
  output logic [WORD_W-1:0] prog_word_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_code_o,
  input  logic              cmd_ready_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  swm_state_e          state;
  swm_next_e           after;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   rx_sh, tx_sh;
  logic                is_ctrl, pull_q, lo_first, wr_txn, sec_sel, mack_q;
  logic [1:0]          wr_cnt;
  logic [ROW_W-1:0]    row_q;
  logic [WORD_W-1:0]   wbuf;
  logic                cmd_v, prog_q;
  logic [BYTE_W-1:0]   cmd_c;

  logic                start_ev, stop_ev, mem_mode, put_low;
  logic [ROW_W-1:0]    row_step;
  logic [BYTE_W-1:0]   tx_first, tx_more;

  assign start_ev = scl_lvl & ~scl_rise & sda_fall;
  assign stop_ev  = scl_lvl & ~scl_rise & sda_rise;
  assign mem_mode = (rx_sh[2:1] == 2'b01) || (rx_sh[2:1] == 2'b10);
  assign put_low  = lo_first ^ (wr_cnt == 2'd1);
  assign row_step = lo_first ? row_q + 1'b1 : row_q - 1'b1;
  assign rd_row_o = (state == ST_RECV) ? rx_sh[BYTE_W-1 -: ROW_W] : row_step;
  assign tx_first = pick_byte(wbuf, lo_first, 1'b0);
  assign tx_more  = sec_sel ? pick_byte(rd_word_i, lo_first, 1'b0)
                            : pick_byte(wbuf, lo_first, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      after    <= NX_HALT;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_ctrl  <= 1'b0;
      pull_q   <= 1'b0;
      lo_first <= 1'b1;
      wr_txn   <= 1'b0;
      sec_sel  <= 1'b0;
      mack_q   <= 1'b0;
      wr_cnt   <= '0;
      row_q    <= '0;
      wbuf     <= '0;
      cmd_v    <= 1'b0;
      cmd_c    <= '0;
      prog_q   <= 1'b0;
    end else begin
      prog_q <= 1'b0;
      if (cmd_v && cmd_ready_i) cmd_v <= 1'b0;

      if (stop_ev) begin
        if (wr_txn && wr_cnt != 2'd0) prog_q <= 1'b1;
        state  <= ST_IDLE;
        pull_q <= 1'b0;
        wr_txn <= 1'b0;
        wr_cnt <= '0;
      end else if (start_ev && state != ST_SPECIAL) begin
        state   <= ST_RECV;
        is_ctrl <= 1'b1;
        bit_cnt <= '0;
        pull_q  <= 1'b0;
        wr_txn  <= 1'b0;
        wr_cnt  <= '0;
      end else begin
        unique case (state)
          ST_RECV: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              state   <= ST_ACK;
              bit_cnt <= '0;
              pull_q  <= 1'b0;
              after   <= NX_HALT;
              if (is_ctrl) begin
                if (busy_i) begin
                  after <= NX_HALT;
                end else if (is_command(rx_sh)) begin
                  if (!cmd_v) begin
                    cmd_v  <= 1'b1;
                    cmd_c  <= rx_sh;
                    pull_q <= 1'b1;
                    after  <= NX_SPECIAL;
                  end
                end else if (mem_mode) begin
                  pull_q   <= 1'b1;
                  row_q    <= rx_sh[BYTE_W-1 -: ROW_W];
                  lo_first <= (rx_sh[2:1] == 2'b01);
                  wbuf     <= rd_word_i;
                  sec_sel  <= 1'b0;
                  if (rx_sh[0]) begin
                    after <= NX_SEND;
                  end else begin
                    after  <= NX_RECV;
                    wr_txn <= 1'b1;
                  end
                end
              end else if (wr_cnt != 2'd2) begin
                pull_q <= 1'b1;
                after  <= NX_RECV;
                wr_cnt <= wr_cnt + 1'b1;
                if (put_low) wbuf[BYTE_W-1:0]      <= rx_sh;
                else         wbuf[WORD_W-1:BYTE_W] <= rx_sh;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              unique case (after)
                NX_RECV: begin
                  state   <= ST_RECV;
                  is_ctrl <= 1'b0;
                  bit_cnt <= '0;
                end
                NX_SEND: begin
                  state   <= ST_SEND;
                  tx_sh   <= {tx_first[BYTE_W-2:0], 1'b0};
                  pull_q  <= ~tx_first[BYTE_W-1];
                  bit_cnt <= CNT_W'(1);
                end
                NX_SPECIAL: state <= ST_SPECIAL;
                default:    state <= ST_HALT;
              endcase
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                pull_q <= 1'b0;
                state  <= ST_MACK;
              end else begin
                pull_q  <= ~tx_sh[BYTE_W-1];
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                if (sec_sel) begin
                  row_q <= row_step;
                  wbuf  <= rd_word_i;
                end
                sec_sel <= ~sec_sel;
                state   <= ST_SEND;
                tx_sh   <= {tx_more[BYTE_W-2:0], 1'b0};
                pull_q  <= ~tx_more[BYTE_W-1];
                bit_cnt <= CNT_W'(1);
              end else begin
                state <= ST_HALT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign prog_o      = prog_q;
  assign prog_row_o  = row_q;
  assign prog_word_o = wbuf;
  assign cmd_valid_o = cmd_v;
  assign cmd_code_o  = cmd_c;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v && !cmd_ready_i) |=> (cmd_v && $stable(cmd_c))); // R10
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && busy_i) |-> !pull_q); // R4
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_lvl); // R13
  AST_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPECIAL) |-> (!pull_q && !prog_q)); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !pull_q); // R7
endmodule

// File: rtl/serial_word_mem.sv
module serial_word_mem
  import swm_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic        cmd_valid_o,
  output logic [7:0]  cmd_code_o,
  input  logic        cmd_ready_i
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [ROW_W-1:0]  rd_row, prog_row;
  logic [WORD_W-1:0] rd_word, prog_word;
  logic              prog, busy;

  swm_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  swm_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  swm_array #(.ROW_BITS(ROW_W), .WIDTH(WORD_W), .BUSY_CYCLES(BUSY_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_row_i(rd_row), .rd_word_o(rd_word),
    .prog_i(prog), .prog_row_i(prog_row), .prog_word_i(prog_word),
    .busy_o(busy));

  swm_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_pull_o(sda_pull_o),
    .rd_row_o(rd_row), .rd_word_i(rd_word), .busy_i(busy),
    .prog_o(prog), .prog_row_o(prog_row), .prog_word_o(prog_word),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o), .cmd_ready_i(cmd_ready_i));
endmodule

// File: tb/serial_word_mem_tb_top.sv
module serial_word_mem_tb_top;
  localparam int BUSY = 600;
  localparam int QT   = 5;
  localparam int HI   = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic cmd_ready = 1'b0;
  logic sda_pull, cmd_valid;
  logic [7:0] cmd_code;
  wire sda_bus = sda_m & ~sda_pull;

  serial_word_mem #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .cmd_ready_i(cmd_ready));

  int checks = 0;
  int errors = 0;
  int r13_viol = 0;
  logic [15:0] ref_mem [32];
  logic [7:0]  got [4];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R13 monitor: slave must not start pulling while SCL is high
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull && !pull_prev && scl_m) r13_viol++;
    pull_prev <= sda_pull;
  end

  task automatic m_start();
    sda_m = 1'b1; wt(QT); scl_m = 1'b1; wt(QT);
    sda_m = 1'b0; wt(QT); scl_m = 1'b0; wt(QT);
  endtask
  task automatic m_stop();
    sda_m = 1'b0; wt(QT); scl_m = 1'b1; wt(QT); sda_m = 1'b1; wt(QT);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; wt(QT); scl_m = 1'b1; wt(HI); scl_m = 1'b0; wt(QT);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(QT); scl_m = 1'b1; wt(HI / 2); b = sda_bus;
    wt(HI / 2); scl_m = 1'b0; wt(QT);
  endtask
  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    acked = ~b;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~give_ack);
  endtask

  function automatic logic [7:0] ctl(input int row, input logic [1:0] mode, input logic rd);
    return {row[4:0], mode, rd};
  endfunction
  function automatic logic [7:0] exp_rd(input int row, input logic [1:0] mode, input int k);
    int r;
    logic lo;
    lo = (mode == 2'b01);
    r  = (row + (lo ? 1 : -1) * (k / 2) + 64) % 32;
    if ((k % 2 == 0) == lo) return ref_mem[r][7:0];
    return ref_mem[r][15:8];
  endfunction

  task automatic do_write(input int row, input logic [1:0] mode, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          output logic third_ack);
    logic a;
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    third_ack = 1'b0;
    m_start();
    send_byte(ctl(row, mode, 1'b0), a);
    chk("R1", "write control ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(bs[i], a);
      if (i < 2) begin
        if ((mode == 2'b01) == (i == 0)) ref_mem[row][7:0] = bs[i];
        else                             ref_mem[row][15:8] = bs[i];
      end else begin
        third_ack = a;
      end
    end
    m_stop();
  endtask

  task automatic poll_ready(output int tries);
    logic a;
    tries = 0;
    a = 1'b0;
    while (!a && tries < 100) begin
      m_start();
      send_byte(ctl(0, 2'b01, 1'b0), a);
      m_stop();
      tries++;
    end
  endtask

  task automatic do_read(input int row, input logic [1:0] mode, input int n);
    logic a;
    m_start();
    send_byte(ctl(row, mode, 1'b1), a);
    chk("R1", "read control ack", a, 1'b1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, got[i]);
    m_stop();
  endtask

  task automatic read_check(input string req, input int row, input logic [1:0] mode, input int n);
    do_read(row, mode, n);
    for (int i = 0; i < n; i++) chk(req, "read byte", got[i], exp_rd(row, mode, i));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic a, t3;
    int tries;
    for (int i = 0; i < 32; i++) ref_mem[i] = 16'h0000;
    wt(10);
    chk("R12", "sda released in reset", sda_pull, 1'b0);
    chk("R12", "cmd_valid low in reset", cmd_valid, 1'b0);
    rst_n = 1'b1;
    wt(10);

    // R12 array reads zero; R6 sequence over reset contents
    read_check("R12", 7, 2'b01, 2);

    // R2 low-first write, R4 busy NACK then poll
    do_write(3, 2'b01, 2, 8'hA1, 8'hB2, 8'h00, t3);
    m_start(); send_byte(ctl(5, 2'b01, 1'b1), a); m_stop();
    chk("R4", "control NACKed while busy", a, 1'b0);
    poll_ready(tries);
    chk("R4", "busy window ended", (tries > 0 && tries < 100), 1'b1);
    read_check("R2", 3, 2'b01, 2);
    read_check("R6", 3, 2'b10, 1);

    // R2 high-first write
    do_write(4, 2'b10, 2, 8'hC3, 8'hD4, 8'h00, t3);
    poll_ready(tries);
    chk("R2", "high-first word", ref_mem[4], 16'hC3D4);
    read_check("R2", 4, 2'b01, 2);

    // R3 one-byte write keeps other half
    do_write(3, 2'b10, 1, 8'h5E, 8'h00, 8'h00, t3);
    poll_ready(tries);
    read_check("R3", 3, 2'b01, 2);

    // R5 control-only write does not program
    m_start(); send_byte(ctl(3, 2'b01, 1'b0), a); m_stop();
    m_start(); send_byte(ctl(3, 2'b01, 1'b1), a);
    chk("R5", "no busy after control-only write", a, 1'b1);
    recv_byte(1'b0, got[0]); m_stop();
    chk("R5", "row unchanged", got[0], ref_mem[3][7:0]);

    // R8 third data byte
    do_write(10, 2'b01, 3, 8'h11, 8'h22, 8'h33, t3);
    chk("R8", "third byte NACKed", t3, 1'b0);
    poll_ready(tries);
    read_check("R8", 10, 2'b01, 2);

    // R6 wraparound both directions
    do_write(31, 2'b01, 2, 8'h31, 8'hF1, 8'h00, t3); poll_ready(tries);
    do_write(0, 2'b01, 2, 8'h0A, 8'h0B, 8'h00, t3);  poll_ready(tries);
    read_check("R6", 31, 2'b01, 4);
    read_check("R6", 0, 2'b10, 4);

    // R7 master NACK: slave silent afterwards
    m_start(); send_byte(ctl(4, 2'b01, 1'b1), a);
    recv_byte(1'b0, got[0]);
    begin
      logic allhi, b;
      allhi = 1'b1;
      for (int i = 0; i < 9; i++) begin rbit(b); allhi &= b; end
      chk("R7", "bus stays high after NACK", allhi, 1'b1);
    end
    m_stop();
    read_check("R7", 4, 2'b10, 2);

    // R11 unsupported control bytes
    m_start(); send_byte(8'h0E, a); chk("R11", "reserved 110 NACK", a, 1'b0);
    send_byte(8'h00, a); chk("R11", "silent after NACK", a, 1'b0); m_stop();
    m_start(); send_byte(8'h18, a); chk("R11", "mode 00 NACK", a, 1'b0); m_stop();
    m_start(); send_byte(8'h3F, a); chk("R11", "mode 11 non-command NACK", a, 1'b0); m_stop();

    // R9 / R10 commands
    m_start(); send_byte(8'hD7, a);
    chk("R9", "command ACK", a, 1'b1);
    chk("R10", "cmd_valid raised", cmd_valid, 1'b1);
    chk("R10", "cmd code", cmd_code, 8'hD7);
    m_start(); send_byte(ctl(3, 2'b01, 1'b1), a);
    chk("R9", "START ignored in command mode", a, 1'b0);
    m_stop();
    wt(20);
    chk("R10", "valid held without ready", cmd_valid, 1'b1);
    chk("R10", "code held without ready", cmd_code, 8'hD7);
    m_start(); send_byte(8'hCF, a); m_stop();
    chk("R10", "second command NACKed while pending", a, 1'b0);
    cmd_ready = 1'b1; wt(3);
    chk("R10", "valid dropped after ready", cmd_valid, 1'b0);
    cmd_ready = 1'b0;
    m_start(); send_byte(8'hC7, a); m_stop();
    chk("R9", "new command ACK", a, 1'b1);
    chk("R9", "new command code", cmd_code, 8'hC7);
    cmd_ready = 1'b1; wt(3); cmd_ready = 1'b0;
    read_check("R9", 10, 2'b01, 1);

    // seeded random traffic
    void'($urandom(32'h5EED));
    for (int it = 0; it < 16; it++) begin
      int row, n;
      logic [1:0] wm, rm;
      row = $urandom() % 32;
      n   = 1 + ($urandom() % 2);
      wm  = ($urandom() % 2) ? 2'b01 : 2'b10;
      rm  = ($urandom() % 2) ? 2'b01 : 2'b10;
      do_write(row, wm, n, 8'($urandom()), 8'($urandom()), 8'h00, t3);
      poll_ready(tries);
      read_check("R2", row, rm, 2);
    end

    chk("R13", "pull only starts with SCL low", r13_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule